// File: doc/BRIEF.md
# Masked Register-Window Copy Channel

This channel copies words between a local memory and a configuration register space in fixed windows of 32 consecutive 32-bit words. One command carries a source address, a destination address, a 32-bit slot mask, a 4-bit window count and an interrupt-enable flag. The channel covers one or more consecutive windows. In each window it visits the word offsets from the lowest to the highest. For every offset the mask leaves open, it reads the source word and writes that word to the destination.

Offsets that the mask closes are skipped and produce no bus traffic. A single command can therefore reach many scattered registers spread over as many as sixteen windows. The block shows whether a copy is running and whether another command is waiting. When interrupts are enabled, it sends a one-cycle pulse after a command ends. The memory interface is a plain read/write port. Read data returns one cycle after the read strobe.

Top module: `mwin_dma`

## Requirements
- R1: After reset, `active`, `pending`, `irq`, `rd_en` and `wr_en` are all low.
- R2: For each open slot, `rd_en` is high for one cycle with `rd_addr` = source base + 128·w + 4·i (window w, offset i). In the next cycle `wr_en` is high with `wr_addr` = destination base + 128·w + 4·i, and `wr_data` equals the word the memory returned for that read.
- R3: A mask bit value of 1 at position i closes offset i in every window, so that offset is neither read nor written. A bit value of 0 opens it.
- R4: Offsets are processed in ascending order within a window, and windows in ascending address order. A count field value of N covers N+1 windows.
- R5: The low five bits of the programmed source and destination addresses are treated as zero.
- R6: `active` rises on the clock edge that accepts a command whose mask opens at least one slot. It stays high through the last write and falls on the edge that completes that write. Every read and write happens while `active` is high.
- R7: A command presented while a copy is running is held: `pending` goes high. After the running copy ends, there is one idle cycle. The held command then starts, and `pending` clears on the edge where it becomes active.
- R8: When the interrupt-enable flag is 1, `irq` is high for exactly one cycle, right after the edge that completes the last write. When the flag is 0, `irq` stays low.
- R9: A command whose mask is all ones causes no reads and no writes, and it leaves `active` low. If the command's interrupt-enable flag is set, `irq` pulses in the cycle after the acceptance edge.
- R10: A further command presented while one is already pending replaces the pending command. The replaced command is never executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_src | input | 16 | Source byte address (low 5 bits ignored) |
| cmd_dst | input | 16 | Destination byte address (low 5 bits ignored) |
| cmd_mask | input | 32 | Slot mask, 1 closes the slot |
| cmd_cnt | input | 4 | Window count minus one |
| cmd_irq_en | input | 1 | Request a completion pulse |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 16 | Memory read byte address |
| rd_data | input | 32 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| active | output | 1 | Copy in progress |
| pending | output | 1 | A command is waiting to start |
| irq | output | 1 | Completion pulse |

## Verification
The command is accepted on edge k. The first read strobe shows in the cycle after edge k, and its write follows exactly one cycle later. The completion pulse and the fall of `active` appear in the cycle after the edge that completes the final write. For an all-ones mask, the pulse appears in the cycle after edge k. The bench drives the strobe at a falling edge and samples every output at later falling edges. It checks the directed timing points at those fixed cycle offsets from acceptance. A scoreboard queue holds the expected read/write pairs in order. A monitor compares every strobe against the head of that queue, so a skipped, extra or reordered access is caught in the cycle where it occurs.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
  localparam int AW       = 16;
  localparam int DW       = 32;
  localparam int SLOTS    = 32;
  localparam int CNT_W    = 4;
  localparam int OFF_W    = $clog2(SLOTS);
  localparam int ALIGN_W  = 5;
  localparam int WIN_BYTES = SLOTS * (DW / 8);

  typedef struct packed {
    logic [AW-1:0]    src;
    logic [AW-1:0]    dst;
    logic [SLOTS-1:0] mask;
    logic [CNT_W-1:0] cnt;
    logic             irq_en;
  } cmd_t;

  // Force the low alignment bits of a programmed address to zero.
  function automatic logic [AW-1:0] align_base(input logic [AW-1:0] a);
    return {a[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};
  endfunction

  // Byte address of a slot inside the current window.
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                               input logic [OFF_W-1:0] off);
    return base + AW'({off, 2'b00});
  endfunction

  // Lowest open slot at or above 'from'; MSB set means none left.
  function automatic logic [OFF_W:0] next_open(input logic [SLOTS-1:0] m,
                                               input logic [OFF_W:0] from);
    logic [OFF_W:0] r;
    r = (OFF_W+1)'(SLOTS);
    for (int i = SLOTS-1; i >= 0; i--) begin
      if (i >= int'(from) && !m[i]) r = (OFF_W+1)'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/mwin_cmd_slot.sv
module mwin_cmd_slot
  import mwin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  cmd_t cmd_in,
  input  logic eng_idle,
  output logic pend_v,
  output logic start,
  output cmd_t start_cmd
);
  cmd_t held_q;
  logic store;
  logic handoff;

  // Hold when the engine is busy or a command already waits (latest wins).
  assign store   = cmd_valid && (!eng_idle || pend_v);
  assign handoff = eng_idle && pend_v;

  assign start     = eng_idle && (pend_v || cmd_valid);
  assign start_cmd = pend_v ? held_q : cmd_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      held_q <= '0;
    end else begin
      if (store) begin
        pend_v <= 1'b1;
        held_q <= cmd_in;
      end else if (handoff) begin
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mwin_walker.sv
module mwin_walker
  import mwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  cmd_t             start_cmd,
  output logic             idle,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    rd_data,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             irq,
  output logic [SLOTS-1:0] cur_mask,
  output logic [OFF_W-1:0] cur_off
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t              st;
  logic [AW-1:0]    src_q, dst_q;
  logic [SLOTS-1:0] mask_q;
  logic [CNT_W-1:0] left_q;
  logic [OFF_W-1:0] off_q;
  logic             irq_en_q, irq_q;

  logic [OFF_W:0]   nxt_in_win, first_cur, first_new;

  assign nxt_in_win = next_open(mask_q, {1'b0, off_q} + 1'b1);
  assign first_cur  = next_open(mask_q, '0);
  assign first_new  = next_open(start_cmd.mask, '0);

  assign idle     = (st == S_IDLE);
  assign rd_en    = (st == S_RD);
  assign wr_en    = (st == S_WR);
  assign rd_addr  = slot_addr(src_q, off_q);
  assign wr_addr  = slot_addr(dst_q, off_q);
  assign wr_data  = rd_data;
  assign irq      = irq_q;
  assign cur_mask = mask_q;
  assign cur_off  = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      mask_q   <= '0;
      left_q   <= '0;
      off_q    <= '0;
      irq_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          src_q    <= align_base(start_cmd.src);
          dst_q    <= align_base(start_cmd.dst);
          mask_q   <= start_cmd.mask;
          left_q   <= start_cmd.cnt;
          irq_en_q <= start_cmd.irq_en;
          if (first_new[OFF_W]) begin
            irq_q <= start_cmd.irq_en;      // nothing open: done at once
          end else begin
            off_q <= first_new[OFF_W-1:0];
            st    <= S_RD;
          end
        end
        S_RD: st <= S_WR;
        S_WR: begin
          if (!nxt_in_win[OFF_W]) begin
            off_q <= nxt_in_win[OFF_W-1:0];
            st    <= S_RD;
          end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            src_q  <= src_q + AW'(WIN_BYTES);
            dst_q  <= dst_q + AW'(WIN_BYTES);
            off_q  <= first_cur[OFF_W-1:0];
            st     <= S_RD;
          end else begin
            irq_q <= irq_en_q;
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwin_dma.sv
module mwin_dma
  import mwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [AW-1:0]    cmd_src,
  input  logic [AW-1:0]    cmd_dst,
  input  logic [SLOTS-1:0] cmd_mask,
  input  logic [CNT_W-1:0] cmd_cnt,
  input  logic             cmd_irq_en,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    rd_data,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             active,
  output logic             pending,
  output logic             irq
);
  cmd_t             cmd_in, start_cmd;
  logic             eng_idle, start;
  logic [SLOTS-1:0] cur_mask;
  logic [OFF_W-1:0] cur_off;

  assign cmd_in = '{src: cmd_src, dst: cmd_dst, mask: cmd_mask,
                    cnt: cmd_cnt, irq_en: cmd_irq_en};

  mwin_cmd_slot u_slot (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_in(cmd_in),
    .eng_idle(eng_idle), .pend_v(pending), .start(start), .start_cmd(start_cmd)
  );

  mwin_walker u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cmd(start_cmd),
    .idle(eng_idle), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq),
    .cur_mask(cur_mask), .cur_off(cur_off)
  );

  assign active = !eng_idle;
endmodule

// File: rtl/mwin_dma_chk.sv
module mwin_dma_chk
  import mwin_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             wr_en,
  input logic [4:0]       rd_lo,
  input logic [4:0]       wr_lo,
  input logic             active,
  input logic             pending,
  input logic             irq,
  input logic [SLOTS-1:0] cur_mask,
  input logic [OFF_W-1:0] cur_off
);
  p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en);

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  p_same_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_lo == $past(rd_lo));

  p_open_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !cur_mask[cur_off]);

  p_traffic_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> active);

  p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !active);

  p_pend_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(active));
endmodule

bind mwin_dma mwin_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
  .rd_lo(rd_addr[4:0]), .wr_lo(wr_addr[4:0]), .active(active),
  .pending(pending), .irq(irq), .cur_mask(cur_mask), .cur_off(cur_off)
);

// File: tb/tb_mwin_dma.sv
`timescale 1ns/100ps
module tb_mwin_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_src = '0, cmd_dst = '0;
  logic [31:0] cmd_mask = '0;
  logic [3:0]  cmd_cnt = '0;
  logic        cmd_irq_en = 1'b0;
  logic        rd_en, wr_en, active, pending, irq;
  logic [15:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;

  always #2.5 clk = ~clk;

  mwin_dma dut (.*);

  // Behavioural target memory: 1024 words, read data one cycle late.
  logic [31:0] mem    [1024];
  logic [31:0] shadow [1024];
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[11:2]];
    if (wr_en) mem[wr_addr[11:2]] <= wr_data;
  end

  typedef struct { logic [15:0] ra; logic [15:0] wa; logic [31:0] wd; } acc_t;
  acc_t q[$];
  int vectors = 0, miscompares = 0, irq_seen = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected access list, restated from R2-R5.
  task automatic push_expect(input logic [15:0] s, input logic [15:0] d,
                             input logic [31:0] m, input int cnt);
    logic [15:0] sb, db;
    sb = {s[15:5], 5'b0};
    db = {d[15:5], 5'b0};
    for (int w = 0; w <= cnt; w++) begin
      for (int i = 0; i < 32; i++) begin
        if (!m[i]) begin
          acc_t a;
          a.ra = sb + 16'(128*w + 4*i);
          a.wa = db + 16'(128*w + 4*i);
          a.wd = shadow[a.ra[11:2]];
          shadow[a.wa[11:2]] = a.wd;
          q.push_back(a);
        end
      end
    end
  endtask

  task automatic issue(input logic [15:0] s, input logic [15:0] d,
                       input logic [31:0] m, input logic [3:0] c,
                       input logic ie, input bit expect_run);
    if (expect_run) push_expect(s, d, m, int'(c));
    cmd_src = s; cmd_dst = d; cmd_mask = m; cmd_cnt = c; cmd_irq_en = ie;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (active || pending || q.size() != 0);
    repeat (3) @(negedge clk);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (irq) irq_seen++;
      if (rd_en) begin
        if (q.size() == 0) check(0, "R3", "unexpected read", {16'h0, rd_addr}, 32'h0);
        else check(rd_addr == q[0].ra, "R2/R4", "read addr", {16'h0, rd_addr}, {16'h0, q[0].ra});
      end
      if (wr_en) begin
        if (q.size() == 0) check(0, "R3", "unexpected write", {16'h0, wr_addr}, 32'h0);
        else begin
          check(wr_addr == q[0].wa, "R2/R4", "write addr", {16'h0, wr_addr}, {16'h0, q[0].wa});
          check(wr_data == q[0].wd, "R2", "write data", wr_data, q[0].wd);
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int base_irq;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
      shadow[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!active && !pending && !irq && !rd_en && !wr_en, "R1", "reset outputs",
          {27'h0, active, pending, irq, rd_en, wr_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Single open slot: exact timing (R6, R8)
    base_irq = irq_seen;
    issue(16'h0000, 16'h0800, 32'hFFFF_FFFE, 4'd0, 1'b1, 1);
    check(active && rd_en, "R6", "active+read after accept", {30'h0, active, rd_en}, 32'h3);
    @(negedge clk);
    check(wr_en && active, "R2", "write one cycle later", {30'h0, wr_en, active}, 32'h3);
    @(negedge clk);
    check(irq && !active, "R8", "irq after last write", {30'h0, irq, active}, 32'h2);
    @(negedge clk);
    check(!irq, "R8", "irq one cycle", {31'h0, irq}, 32'h0);
    wait_idle();
    check(irq_seen - base_irq == 1, "R8", "irq count", irq_seen - base_irq, 1);

    // Sparse mask, three windows, unaligned addresses (R2-R5)
    base_irq = irq_seen;
    issue(16'h0113, 16'h091F, 32'hAAAA_5555, 4'd2, 1'b1, 1);
    wait_idle();
    check(irq_seen - base_irq == 1, "R4", "irq count multi-window", irq_seen - base_irq, 1);
    check(mem[12'h93C >> 2] == shadow[12'h93C >> 2], "R5", "dst word aligned",
          mem[12'h93C >> 2], shadow[12'h93C >> 2]);

    // Irq disabled (R8)
    base_irq = irq_seen;
    issue(16'h0280, 16'h0A80, 32'h0000_0000, 4'd0, 1'b0, 1);
    wait_idle();
    check(irq_seen == base_irq, "R8", "no irq when disabled", irq_seen - base_irq, 0);

    // All slots closed, sixteen windows (R9)
    base_irq = irq_seen;
    issue(16'h0000, 16'h0E00, 32'hFFFF_FFFF, 4'd15, 1'b1, 1);
    check(irq && !active, "R9", "immediate irq", {30'h0, irq, active}, 32'h2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!active && !rd_en && !wr_en, "R9", "no traffic", {29'h0, active, rd_en, wr_en}, 32'h0);
    end
    check(irq_seen - base_irq == 1, "R9", "single irq", irq_seen - base_irq, 1);

    // Pending and replacement (R7, R10)
    base_irq = irq_seen;
    issue(16'h0300, 16'h0B00, 32'h0000_0000, 4'd1, 1'b1, 1);
    repeat (3) @(negedge clk);
    issue(16'h0400, 16'h0D00, 32'h0000_0000, 4'd0, 1'b1, 0);
    check(pending && active, "R7", "held while busy", {30'h0, pending, active}, 32'h3);
    issue(16'h0800, 16'h0C00, 32'h0F0F_0F0F, 4'd0, 1'b1, 1);
    check(pending, "R10", "still one pending", {31'h0, pending}, 32'h1);
    do @(negedge clk); while (active);
    check(pending && !active, "R7", "idle gap before handoff", {30'h0, pending, active}, 32'h2);
    @(negedge clk);
    check(!pending && active, "R7", "pending clears on start", {30'h0, pending, active}, 32'h1);
    wait_idle();
    check(irq_seen - base_irq == 2, "R10", "two commands executed", irq_seen - base_irq, 2);
    check(mem[12'hD00 >> 2] == shadow[12'hD00 >> 2], "R10", "replaced cmd untouched",
          mem[12'hD00 >> 2], shadow[12'hD00 >> 2]);

    done = 1;
    summary();
    $finish;
  end
endmodule